// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

This peripheral holds two independent down-counters behind a small register bus. Both share one control register that carries, for each counter, a run bit and an auto-reload bit. Each counter also has its own reload register and a current-value register. Software can read the current-value register and also write it, and counting carries on from the written value. A count step happens only on a cycle where the `tick` input is high. This lets the counters run at a rate below the clock.

Counter 0 is intended as a free-running time base. When its reload and value registers are both loaded with all ones and auto-reload is on, it sweeps the full 32-bit range without end. Software inverts the value it reads to get a count that rises. Counter 1 is the event counter and produces a one-cycle interrupt pulse when it expires. It works either as a one-shot, which stops at zero, or as a periodic source, which wraps to its reload value. A reload value of N gives a period of N+1 ticks.

Top module: `dual_timer`

## Requirements
- R1: After synchronous reset, every register reads zero and `irq_t1` is low.
- R2: The control register sits at offset 0x00 and uses four bits. Bit 0 runs counter 0 and bit 1 enables auto-reload on counter 0. Bit 2 runs counter 1 and bit 3 enables auto-reload on counter 1. Bits 31:4 always read zero.
- R3: The register offsets are: counter 0 reload at 0x10, counter 0 value at 0x14, counter 1 reload at 0x18 and counter 1 value at 0x1C. Any other offset reads zero, and a write to it changes no register.
- R4: A running counter decrements by one on each cycle where `tick` is high, and it holds on any other cycle. A counter whose run bit is clear stays frozen.
- R5: A write to a value register loads the counter on the next clock edge. This write takes priority over a tick in the same cycle, and that tick causes no expiry.
- R6: A running counter expires on a tick at which it holds zero. With auto-reload set, it then loads its reload value. A reload value of N therefore gives a period of N+1 ticks.
- R7: With auto-reload clear, the counter holds at zero after it expires, and it neither counts nor expires again until its value or the control register is written. Its run bit still reads as written.
- R8: `irq_t1` goes high for exactly the one cycle after the clock edge at which counter 1 expires. An expiry of counter 0 never raises it.
- R9: When counter 0 holds zero with reload value 0xFFFFFFFF and auto-reload set, it wraps to 0xFFFFFFFF on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count-step enable |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_t1 | output | 1 | Counter-1 expiry pulse |

## Verification
The bound checker tests some properties on every cycle. A counter must hold when there is neither a tick nor a write, and it must stay frozen while its run bit is clear. On every step it must decrement by exactly one. At expiry it must load its reload value or hold at zero, depending on its mode. Every interrupt pulse must follow a tick taken while counter 1 held zero. Other behaviours need the bench's scenarios: the register map and the unmapped offsets, the N+1 period over several wraps, write priority over a simultaneous tick, the one-shot staying silent after its first expiry, and the full-range wrap. Each of these depends on a sequence of bus accesses and ticks, with results known only from the requirements.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int NUM_TMR = 2;
    localparam int CTRL_W  = 2 * NUM_TMR;
    localparam int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_BANK    = 8'h10;
    localparam int                BANK_STRIDE = 8;

    // Per-counter configuration; run is the lower bit of each pair.
    typedef struct packed {
        logic reload;
        logic run;
    } tmr_cfg_t;

    typedef tmr_cfg_t [NUM_TMR-1:0] cfg_bank_t;

    function automatic logic [ADDR_W-1:0] reload_off(input int idx);
        return OFF_BANK + ADDR_W'(idx * BANK_STRIDE);
    endfunction

    function automatic logic [ADDR_W-1:0] value_off(input int idx);
        return OFF_BANK + ADDR_W'(idx * BANK_STRIDE + 4);
    endfunction
endpackage

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  tmr_cfg_t         cfg,
    input  logic             cfg_wr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             stopped_q;
    logic             step;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    assign step    = tick && cfg.run && !stopped_q && !ld;
    assign expire  = step && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            stopped_q <= 1'b0;
        end else if (ld) begin
            cnt_q     <= ld_val;
            stopped_q <= 1'b0;
        end else begin
            if (step) begin
                if (!at_zero) begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end else if (cfg.reload) begin
                    cnt_q <= reload_val;
                end else begin
                    stopped_q <= 1'b1;
                end
            end
            if (cfg_wr) begin
                stopped_q <= 1'b0;
            end
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dtmr_regfile.sv
module dtmr_regfile
    import dtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt_i   [NUM_TMR],
    output cfg_bank_t         cfg_o,
    output logic              cfg_wr_o,
    output logic [CNT_W-1:0]  rel_o   [NUM_TMR],
    output logic [NUM_TMR-1:0] ld_o
);
    cfg_bank_t cfg_q;

    assign cfg_wr_o = bus_wr && (bus_addr == OFF_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_wr_o) begin
            cfg_q <= cfg_bank_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_bank
        logic [CNT_W-1:0] rel_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                rel_q <= '0;
            end else if (bus_wr && (bus_addr == reload_off(gi))) begin
                rel_q <= bus_wdata;
            end
        end

        assign rel_o[gi] = rel_q;
        assign ld_o[gi]  = bus_wr && (bus_addr == value_off(gi));
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_CTRL) begin
            bus_rdata = CNT_W'(cfg_q);
        end
        for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr == reload_off(i)) bus_rdata = rel_o[i];
            if (bus_addr == value_off(i))  bus_rdata = cnt_i[i];
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_t1
);
    cfg_bank_t          cfg_w;
    logic               cfg_wr_w;
    logic [CNT_W-1:0]   rel_w [NUM_TMR];
    logic [CNT_W-1:0]   cnt_w [NUM_TMR];
    logic [NUM_TMR-1:0] ld_w;
    logic [NUM_TMR-1:0] exp_w;
    logic [CTRL_W-1:0]  cfg_bits_w;
    logic               irq_q;

    assign cfg_bits_w = cfg_w;

    dtmr_regfile #(.CNT_W(CNT_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cnt_i    (cnt_w),
        .cfg_o    (cfg_w),
        .cfg_wr_o (cfg_wr_w),
        .rel_o    (rel_w),
        .ld_o     (ld_w)
    );

    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_chan
        dtmr_channel #(.CNT_W(CNT_W)) chan_i (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .cfg       (cfg_w[gi]),
            .cfg_wr    (cfg_wr_w),
            .ld        (ld_w[gi]),
            .ld_val    (bus_wdata),
            .reload_val(rel_w[gi]),
            .cnt       (cnt_w[gi]),
            .expire    (exp_w[gi])
        );
    end

    // Only the event counter (index 1) drives the interrupt.
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= exp_w[1];
    end

    assign irq_t1 = irq_q;
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             bus_wr,
    input logic             irq,
    input logic [3:0]       cfg_bits,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cnt1,
    input logic [CNT_W-1:0] rel0
);
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !bus_wr) |=> ($stable(cnt0) && $stable(cnt1)));

    p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bits[0] && !bus_wr) |=> $stable(cnt0));

    p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !bus_wr && cfg_bits[0] && cnt0 != '0) |=> (cnt0 == $past(cnt0) - CNT_W'(1)));

    p_wrap_reload_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !bus_wr && cfg_bits[0] && cfg_bits[1] && cnt0 == '0) |=> (cnt0 == $past(rel0)));

    p_oneshot_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && !bus_wr && cfg_bits[2] && !cfg_bits[3] && cnt1 == '0) |=> (cnt1 == '0));

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(tick) && $past(cnt1) == '0 && $past(cfg_bits[2])));
endmodule

bind dual_timer dual_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .bus_wr  (bus_wr),
    .irq     (irq_t1),
    .cfg_bits(cfg_bits_w),
    .cnt0    (cnt_w[0]),
    .cnt1    (cnt_w[1]),
    .rel0    (rel_w[0])
);

// File: tb/dual_timer_tb_top.sv
`timescale 1ns/1ps
module dual_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_t1;

    int checks = 0;
    int failures = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    dual_timer dut_i (
        .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_t1(irq_t1)
    );

    typedef struct packed {
        logic [31:0] val;
        logic [31:0] rel;
        logic        rl;
        logic [7:0]  n;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{val: 32'd5,  rel: 32'd3, rl: 1'b1, n: 8'd2,  exp: 32'd3},
        '{val: 32'd5,  rel: 32'd3, rl: 1'b1, n: 8'd6,  exp: 32'd3},
        '{val: 32'd5,  rel: 32'd3, rl: 1'b1, n: 8'd8,  exp: 32'd1},
        '{val: 32'd5,  rel: 32'd3, rl: 1'b0, n: 8'd8,  exp: 32'd0},
        '{val: 32'd0,  rel: 32'd7, rl: 1'b1, n: 8'd1,  exp: 32'd7},
        '{val: 32'd2,  rel: 32'd4, rl: 1'b1, n: 8'd9,  exp: 32'd3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdr(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rdr(8'h00, rd); check("R1 ctrl", rd, 0);
        rdr(8'h10, rd); check("R1 rel0", rd, 0);
        rdr(8'h14, rd); check("R1 val0", rd, 0);
        rdr(8'h18, rd); check("R1 rel1", rd, 0);
        rdr(8'h1C, rd); check("R1 val1", rd, 0);
        check("R1 irq", {31'b0, irq_t1}, 0);

        // R2: control bits read back, upper bits zero
        wr(8'h00, 32'hFFFF_FFF0); rdr(8'h00, rd); check("R2 upper", rd, 0);
        wr(8'h00, 32'h0000_000A); rdr(8'h00, rd); check("R2 reload bits", rd, 32'hA);
        wr(8'h00, 32'h0);

        // R3: map and unmapped offsets
        wr(8'h10, 32'h1111_0000); wr(8'h18, 32'h2222_0000);
        rdr(8'h10, rd); check("R3 rel0", rd, 32'h1111_0000);
        rdr(8'h18, rd); check("R3 rel1", rd, 32'h2222_0000);
        wr(8'h04, 32'hDEAD_BEEF); wr(8'h20, 32'hDEAD_BEEF);
        rdr(8'h04, rd); check("R3 unmapped read", rd, 0);
        rdr(8'h10, rd); check("R3 unmapped write rel0", rd, 32'h1111_0000);
        rdr(8'h14, rd); check("R3 unmapped write val0", rd, 0);
        rdr(8'h00, rd); check("R3 unmapped write ctrl", rd, 0);

        // Vector table on counter 0 (R4 decrement, R6 reload, R7 one-shot)
        foreach (VECS[k]) begin
            wr(8'h00, 32'h0);
            wr(8'h10, VECS[k].rel);
            wr(8'h14, VECS[k].val);
            wr(8'h00, {30'b0, VECS[k].rl, 1'b1});
            ticks(int'(VECS[k].n));
            rdr(8'h14, rd);
            check(VECS[k].rl ? "R6 vector" : "R7 vector", rd, VECS[k].exp);
        end

        // R4: no tick means hold; cleared run bit freezes
        wr(8'h00, 32'h0); wr(8'h14, 32'd50); wr(8'h00, 32'h1);
        repeat (5) @(negedge clk);
        rdr(8'h14, rd); check("R4 hold without tick", rd, 32'd50);
        ticks(3); rdr(8'h14, rd); check("R4 decrement", rd, 32'd47);
        wr(8'h00, 32'h0); ticks(4);
        rdr(8'h14, rd); check("R4 frozen", rd, 32'd47);

        // R5: write beats simultaneous tick
        wr(8'h00, 32'h4); wr(8'h1C, 32'd0);
        @(negedge clk); tick = 1'b1; bus_wr = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'd9;
        @(negedge clk); tick = 1'b0; bus_wr = 1'b0;
        check("R5 no irq", {31'b0, irq_t1}, 0);
        rdr(8'h1C, rd); check("R5 write wins", rd, 32'd9);

        // R8 / R7: one-shot counter 1 interrupt
        wr(8'h00, 32'h0); wr(8'h1C, 32'd2); wr(8'h00, 32'h4);
        ticks(2);
        check("R8 no early irq", {31'b0, irq_t1}, 0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check("R8 irq pulse", {31'b0, irq_t1}, 1);
        @(negedge clk);
        check("R8 irq one cycle", {31'b0, irq_t1}, 0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check("R7 no second irq", {31'b0, irq_t1}, 0);
        rdr(8'h1C, rd); check("R7 held at zero", rd, 0);
        rdr(8'h00, rd); check("R7 run bit stays", rd, 32'h4);

        // R8: counter 0 expiry raises nothing
        wr(8'h00, 32'h0); wr(8'h14, 32'd0); wr(8'h10, 32'd3); wr(8'h00, 32'h3);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check("R8 counter0 silent", {31'b0, irq_t1}, 0);

        // R9: full-range wrap
        wr(8'h00, 32'h0); wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'h0); wr(8'h00, 32'h3);
        ticks(1); rdr(8'h14, rd); check("R9 wrap", rd, 32'hFFFF_FFFF);
        ticks(2); rdr(8'h14, rd); check("R9 continue", rd, 32'hFFFF_FFFD);

        // R1: reset mid-run clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rdr(8'h14, rd); check("R1 reset val0", rd, 0);
        rdr(8'h00, rd); check("R1 reset ctrl", rd, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule